// File: doc/BRIEF.md
# Serial Mode-Register Port with Track Counter

This block is the slave end of a three-wire link from a host microcontroller. The host presents one data bit per serial clock, least significant bit first, and then strobes a latch line. On the latch's rising edge the block commits the shifted word to a control register. The word length is taken from the number of clock pulses since the previous latch. An 8-bit word carries a register address in its upper nibble and four data bits in its lower nibble. A 16-bit word carries a fixed upper byte that names one of two function registers, and the control bits are in its lower byte. All inputs are asynchronous to the block clock and pass through synchronizers before use.

Two of the short-word addresses load the low and high halves of an 8-bit track-jump counter. Each rising edge of an external track pulse decrements the counter. One shared status output is driven from a source chosen by the last address sent. The sources are external status levels, the counter's completion and decrement-toggle flags, and the track pulse itself. After either function register is written, the status output is released to high impedance, modelled as an output enable.

Top module: `ser_ctl_if`

## Requirements
- R1: Bits are taken on each rising serial-clock edge, least significant first. The word is committed on the latch's rising edge. In a short word, bits 7:4 are the address and bits 3:0 are the data.
- R2: Short words with address 0x9, 0xA, 0xD, 0xE or 0xF copy their data nibble to `audio_ctl_o`, `sync_ctl_o`, `servo_ctl_o`, `clv_mode_o` or `speed_ctl_o` respectively. No other register output changes.
- R3: A 16-bit word with upper byte 0x88 sets `deemph_en_o` from bit 5 and `erasure_off_o` from bit 4. A 16-bit word with upper byte 0x8D sets `ext_buf_en_o` from bit 1 and `mon_off_o` from bit 0.
- R4: The following are ignored and change no register and no status selection: a latch after any bit count other than 8 or 16, a short word with address 0x0 to 0x8, and a 16-bit word whose upper byte is neither 0x88 nor 0x8D.
- R5: Status selection follows the last valid address, with `status_oe_o` high. The sources are: 0x9 subcode sync, 0xA frame-sync lock, 0xB completion flag (low when done), 0xC decrement toggle, 0xD focus OK, 0xE long-pulse flag, 0xF the synchronized track pulse.
- R6: A committed 0x88 or 0x8D word drops `status_oe_o` low, and `status_o` reads 0 while released.
- R7: The status selection changes as soon as the eighth bit arrives whose upper nibble is 0x9 to 0xF, without any latch pulse.
- R8: Address 0xB loads the counter's low nibble and address 0xC loads its high nibble. The other nibble keeps the value last written to it.
- R9: Each rising edge of the track pulse decrements a nonzero counter by one. At zero the counter stays at zero.
- R10: The completion flag is low exactly when the counter is zero. The toggle flag inverts on every decrement and on nothing else.
- R11: After reset every register output, the counter and both flags are 0, and `status_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock from host |
| ser_dat_i | input | 1 | Serial data from host |
| ser_lat_i | input | 1 | Latch strobe from host |
| trk_pulse_i | input | 1 | Track crossing pulse |
| sub_sync_i | input | 1 | Subcode sync level |
| fs_lock_i | input | 1 | Frame-sync lock level |
| focus_ok_i | input | 1 | Focus OK level |
| pw_long_n_i | input | 1 | Long-pulse flag, active low |
| audio_ctl_o | output | 4 | Register at address 0x9 |
| sync_ctl_o | output | 4 | Register at address 0xA |
| servo_ctl_o | output | 4 | Register at address 0xD |
| clv_mode_o | output | 4 | Register at address 0xE |
| speed_ctl_o | output | 4 | Register at address 0xF |
| deemph_en_o | output | 1 | De-emphasis enable |
| erasure_off_o | output | 1 | Erasure correction disable |
| ext_buf_en_o | output | 1 | External shock-buffer interface enable |
| mon_off_o | output | 1 | Monitor outputs disable |
| status_o | output | 1 | Multiplexed status |
| status_oe_o | output | 1 | Status output enable |

## Verification
The assertions assume that a serial-clock edge and a latch edge never reach the decoder in the same clock cycle. When they do coincide, the latch takes priority and that data bit is lost. They also assume that every host line is held for several block clocks, so that each level passes the synchronizers intact. The bench holds every data bit, clock phase, latch pulse and track pulse for at least three clock cycles. It keeps the latch low while shifting and waits for the synchronizers to settle before sampling any output.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int NIB_W    = 4;
  localparam int CNT_W    = 2 * NIB_W;
  localparam int WORD_S   = 8;
  localparam int WORD_L   = 16;
  localparam int BCNT_W   = $clog2(WORD_L + 2);
  localparam logic [7:0] FN_A_BYTE = 8'h88;
  localparam logic [7:0] FN_B_BYTE = 8'h8D;

  typedef enum logic [NIB_W-1:0] {
    SEL_OFF  = 4'h0,
    SEL_SUB  = 4'h9,
    SEL_LOCK = 4'hA,
    SEL_DONE = 4'hB,
    SEL_TOG  = 4'hC,
    SEL_FOK  = 4'hD,
    SEL_PW   = 4'hE,
    SEL_TRK  = 4'hF
  } sel_e;

  typedef struct packed {
    logic [NIB_W-1:0] audio;
    logic [NIB_W-1:0] sync;
    logic [NIB_W-1:0] servo;
    logic [NIB_W-1:0] clv;
    logic [NIB_W-1:0] speed;
    logic             deemph;
    logic             era_off;
    logic             ext_buf;
    logic             mon_off;
  } regs_t;
endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      prev_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ser_ctl_dec.sv
module ser_ctl_dec
  import ser_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_rise_i,
  input  logic             sdat_i,
  input  logic             lat_rise_i,
  output regs_t            regs_o,
  output sel_e             sel_o,
  output logic             ld_lo_o,
  output logic             ld_hi_o,
  output logic [NIB_W-1:0] ld_nib_o,
  output logic             fn_hit_o
);
  logic [WORD_L-1:0] sr_q;
  logic [BCNT_W-1:0] bcnt_q;
  regs_t             regs_q;
  sel_e              sel_q;
  logic [NIB_W-1:0]  peek_addr;
  logic [NIB_W-1:0]  s_addr, s_data;
  logic [7:0]        l_hi;

  assign peek_addr = {sdat_i, sr_q[WORD_L-1 -: NIB_W-1]};
  assign s_addr    = sr_q[WORD_L-1 -: NIB_W];
  assign s_data    = sr_q[WORD_L-NIB_W-1 -: NIB_W];
  assign l_hi      = sr_q[WORD_L-1 -: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      bcnt_q   <= '0;
      regs_q   <= '0;
      sel_q    <= SEL_OFF;
      ld_lo_o  <= 1'b0;
      ld_hi_o  <= 1'b0;
      ld_nib_o <= '0;
      fn_hit_o <= 1'b0;
    end else begin
      ld_lo_o  <= 1'b0;
      ld_hi_o  <= 1'b0;
      fn_hit_o <= 1'b0;
      if (lat_rise_i) begin
        bcnt_q <= '0;
        if (bcnt_q == BCNT_W'(WORD_S)) begin
          case (s_addr)
            4'h9: begin regs_q.audio <= s_data; sel_q <= SEL_SUB;  end
            4'hA: begin regs_q.sync  <= s_data; sel_q <= SEL_LOCK; end
            4'hB: begin ld_lo_o <= 1'b1; ld_nib_o <= s_data; sel_q <= SEL_DONE; end
            4'hC: begin ld_hi_o <= 1'b1; ld_nib_o <= s_data; sel_q <= SEL_TOG;  end
            4'hD: begin regs_q.servo <= s_data; sel_q <= SEL_FOK;  end
            4'hE: begin regs_q.clv   <= s_data; sel_q <= SEL_PW;   end
            4'hF: begin regs_q.speed <= s_data; sel_q <= SEL_TRK;  end
            default: ;
          endcase
        end else if (bcnt_q == BCNT_W'(WORD_L)) begin
          if (l_hi == FN_A_BYTE) begin
            regs_q.deemph  <= sr_q[5];
            regs_q.era_off <= sr_q[4];
            sel_q          <= SEL_OFF;
            fn_hit_o       <= 1'b1;
          end else if (l_hi == FN_B_BYTE) begin
            regs_q.ext_buf <= sr_q[1];
            regs_q.mon_off <= sr_q[0];
            sel_q          <= SEL_OFF;
            fn_hit_o       <= 1'b1;
          end
        end
      end else if (sclk_rise_i) begin
        sr_q <= {sdat_i, sr_q[WORD_L-1:1]};
        if (bcnt_q != BCNT_W'(WORD_L + 1)) bcnt_q <= bcnt_q + 1'b1;
        // status re-select on the eighth bit, no latch needed
        if (bcnt_q == BCNT_W'(WORD_S - 1) && peek_addr >= 4'h9)
          sel_q <= sel_e'(peek_addr);
      end
    end
  end

  assign regs_o = regs_q;
  assign sel_o  = sel_q;

  a_r4_odd_length_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_rise_i && bcnt_q != BCNT_W'(WORD_S) && bcnt_q != BCNT_W'(WORD_L))
      |=> ($stable(regs_q) && $stable(sel_q) && !ld_lo_o && !ld_hi_o));

  a_r4_low_addr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_rise_i && bcnt_q == BCNT_W'(WORD_S) && s_addr < 4'h9)
      |=> ($stable(regs_q) && $stable(sel_q)));

  a_r8_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_lo_o && ld_hi_o));
endmodule

// File: rtl/ser_ctl_trk.sv
module ser_ctl_trk
  import ser_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_lo_i,
  input  logic             ld_hi_i,
  input  logic [NIB_W-1:0] ld_nib_i,
  input  logic             trk_rise_i,
  output logic             done_n_o,
  output logic             tog_o
);
  logic [NIB_W-1:0] lo_q, hi_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dec;

  assign dec = trk_rise_i && !ld_lo_i && !ld_hi_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cnt_q <= '0;
      tog_o <= 1'b0;
    end else begin
      if (ld_lo_i) begin
        lo_q  <= ld_nib_i;
        cnt_q <= {hi_q, ld_nib_i};
      end else if (ld_hi_i) begin
        hi_q  <= ld_nib_i;
        cnt_q <= {ld_nib_i, lo_q};
      end else if (dec) begin
        cnt_q <= cnt_q - 1'b1;
        tog_o <= ~tog_o;
      end
    end
  end

  assign done_n_o = (cnt_q != '0);

  a_r9_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_rise_i && !ld_lo_i && !ld_hi_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r9_hold_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !ld_lo_i && !ld_hi_i) |=> (cnt_q == '0));

  a_r10_toggle_only_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trk_rise_i || cnt_q == '0 || ld_lo_i || ld_hi_i) |=> $stable(tog_o));

  a_r8_hi_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hi_i |=> (cnt_q[CNT_W-1 -: NIB_W] == $past(ld_nib_i)));
endmodule

// File: rtl/ser_ctl_mux.sv
module ser_ctl_mux
  import ser_ctl_pkg::*;
(
  input  sel_e sel_i,
  input  logic sub_sync_i,
  input  logic fs_lock_i,
  input  logic done_n_i,
  input  logic tog_i,
  input  logic focus_ok_i,
  input  logic pw_long_n_i,
  input  logic trk_lvl_i,
  output logic status_o,
  output logic status_oe_o
);
  always_comb begin
    status_oe_o = 1'b1;
    unique case (sel_i)
      SEL_SUB:  status_o = sub_sync_i;
      SEL_LOCK: status_o = fs_lock_i;
      SEL_DONE: status_o = done_n_i;
      SEL_TOG:  status_o = tog_i;
      SEL_FOK:  status_o = focus_ok_i;
      SEL_PW:   status_o = pw_long_n_i;
      SEL_TRK:  status_o = trk_lvl_i;
      default: begin
        status_o    = 1'b0;
        status_oe_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ser_ctl_if.sv
module ser_ctl_if
  import ser_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_lat_i,
  input  logic             trk_pulse_i,
  input  logic             sub_sync_i,
  input  logic             fs_lock_i,
  input  logic             focus_ok_i,
  input  logic             pw_long_n_i,
  output logic [NIB_W-1:0] audio_ctl_o,
  output logic [NIB_W-1:0] sync_ctl_o,
  output logic [NIB_W-1:0] servo_ctl_o,
  output logic [NIB_W-1:0] clv_mode_o,
  output logic [NIB_W-1:0] speed_ctl_o,
  output logic             deemph_en_o,
  output logic             erasure_off_o,
  output logic             ext_buf_en_o,
  output logic             mon_off_o,
  output logic             status_o,
  output logic             status_oe_o
);
  localparam int N_IN = 4;
  logic [N_IN-1:0] raw, lvl, rise;
  regs_t            regs;
  sel_e             sel;
  logic             ld_lo, ld_hi, fn_hit, done_n, tog;
  logic [NIB_W-1:0] ld_nib;

  assign raw = {trk_pulse_i, ser_lat_i, ser_dat_i, ser_clk_i};

  ser_ctl_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .lvl_o(lvl), .rise_o(rise)
  );

  ser_ctl_dec u_dec (
    .clk_i, .rst_ni,
    .sclk_rise_i(rise[0]), .sdat_i(lvl[1]), .lat_rise_i(rise[2]),
    .regs_o(regs), .sel_o(sel),
    .ld_lo_o(ld_lo), .ld_hi_o(ld_hi), .ld_nib_o(ld_nib), .fn_hit_o(fn_hit)
  );

  ser_ctl_trk u_trk (
    .clk_i, .rst_ni,
    .ld_lo_i(ld_lo), .ld_hi_i(ld_hi), .ld_nib_i(ld_nib),
    .trk_rise_i(rise[3]), .done_n_o(done_n), .tog_o(tog)
  );

  ser_ctl_mux u_mux (
    .sel_i(sel), .sub_sync_i, .fs_lock_i, .done_n_i(done_n), .tog_i(tog),
    .focus_ok_i, .pw_long_n_i, .trk_lvl_i(lvl[3]),
    .status_o, .status_oe_o
  );

  assign audio_ctl_o   = regs.audio;
  assign sync_ctl_o    = regs.sync;
  assign servo_ctl_o   = regs.servo;
  assign clv_mode_o    = regs.clv;
  assign speed_ctl_o   = regs.speed;
  assign deemph_en_o   = regs.deemph;
  assign erasure_off_o = regs.era_off;
  assign ext_buf_en_o  = regs.ext_buf;
  assign mon_off_o     = regs.mon_off;

  a_r6_release_after_fn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn_hit |-> !status_oe_o);

  a_r10_done_tracks_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_lo && ld_nib != '0) |=> done_n);
endmodule

// File: tb/tb_ser_ctl_if.sv
module tb_ser_ctl_if;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdat = 0, slat = 0, trk = 0;
  logic sub = 0, lock = 0, fok = 0, pwn = 0;
  logic [3:0] audio, sync, servo, clv, speed;
  logic deemph, era, ext, mon, st, st_oe;
  int checks = 0, errors = 0;
  logic [3:0] e_audio = 0, e_sync = 0, e_servo = 0, e_clv = 0, e_speed = 0;
  logic e_de = 0, e_era = 0, e_ext = 0, e_mon = 0;

  always #2.5 clk = ~clk;

  ser_ctl_if dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_lat_i(slat),
    .trk_pulse_i(trk), .sub_sync_i(sub), .fs_lock_i(lock), .focus_ok_i(fok),
    .pw_long_n_i(pwn), .audio_ctl_o(audio), .sync_ctl_o(sync), .servo_ctl_o(servo),
    .clv_mode_o(clv), .speed_ctl_o(speed), .deemph_en_o(deemph), .erasure_off_o(era),
    .ext_buf_en_o(ext), .mon_off_o(mon), .status_o(st), .status_oe_o(st_oe)
  );

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift(logic [15:0] v, int n);
    for (int i = 0; i < n; i++) begin
      sdat = v[i];
      wclk(3);
      sclk = 1;
      wclk(3);
      sclk = 0;
      wclk(3);
    end
  endtask

  task automatic latch();
    slat = 1;
    wclk(4);
    slat = 0;
    wclk(6);
  endtask

  task automatic frame(logic [15:0] v, int n);
    shift(v, n);
    latch();
  endtask

  task automatic trk_pulse();
    trk = 1;
    wclk(4);
    trk = 0;
    wclk(6);
  endtask

  task automatic chk_regs(string req);
    chk(req, {audio, sync, servo, clv, speed, deemph, era, ext, mon},
             {e_audio, e_sync, e_servo, e_clv, e_speed, e_de, e_era, e_ext, e_mon});
  endtask

  initial begin
    logic [3:0] addrs[5];
    logic t0;
    addrs = '{4'h9, 4'hA, 4'hD, 4'hE, 4'hF};
    wclk(3);
    // R11 reset state
    chk_regs("R11");
    chk("R11 oe", {st_oe, st}, 2'b00);
    rst_n = 1;
    wclk(4);
    chk_regs("R11");
    chk("R11 oe", st_oe, 1'b0);

    // R1 R2: all addresses, all data values
    for (int a = 0; a < 5; a++) begin
      for (int d = 0; d < 16; d++) begin
        frame({8'h00, addrs[a], 4'(d)}, 8);
        case (addrs[a])
          4'h9: e_audio = 4'(d);
          4'hA: e_sync  = 4'(d);
          4'hD: e_servo = 4'(d);
          4'hE: e_clv   = 4'(d);
          default: e_speed = 4'(d);
        endcase
        chk_regs("R2");
      end
    end

    // R3 function registers, all bit combinations
    for (int b = 0; b < 4; b++) begin
      frame({8'h88, 2'b00, 2'(b), 4'b0000}, 16);
      e_de = b[1]; e_era = b[0];
      chk_regs("R3");
      chk("R6 released", {st_oe, st}, 2'b00);
      frame({8'h8D, 6'b000000, 2'(b)}, 16);
      e_ext = b[1]; e_mon = b[0];
      chk_regs("R3");
      chk("R6 released", {st_oe, st}, 2'b00);
    end
    // wrong bits ignored
    frame(16'h88CF, 16);
    e_de = 0; e_era = 0;
    chk_regs("R3");

    // R5: each selection with its source driven both ways
    frame(16'h0095, 8); e_audio = 4'h5;
    for (int v = 0; v < 2; v++) begin sub = v[0]; wclk(2); chk("R5 sub", {st_oe, st}, {1'b1, v[0]}); end
    frame(16'h00A6, 8); e_sync = 4'h6;
    for (int v = 0; v < 2; v++) begin lock = v[0]; wclk(2); chk("R5 lock", {st_oe, st}, {1'b1, v[0]}); end
    frame(16'h00D7, 8); e_servo = 4'h7;
    for (int v = 0; v < 2; v++) begin fok = v[0]; wclk(2); chk("R5 fok", {st_oe, st}, {1'b1, v[0]}); end
    frame(16'h00E8, 8); e_clv = 4'h8;
    for (int v = 0; v < 2; v++) begin pwn = v[0]; wclk(2); chk("R5 pw", {st_oe, st}, {1'b1, v[0]}); end
    frame(16'h00F9, 8); e_speed = 4'h9;
    trk = 1; wclk(5); chk("R5 trk", {st_oe, st}, 2'b11);
    trk = 0; wclk(5); chk("R5 trk", {st_oe, st}, 2'b10);
    chk_regs("R2");

    // R4: ignored frames keep registers and selection (still 0xF -> trk low)
    for (int a = 0; a < 9; a++) begin
      frame({8'h00, 4'(a), 4'hA}, 8);
      chk_regs("R4 low addr");
      chk("R4 sel", {st_oe, st}, 2'b10);
    end
    frame(16'h89FF, 16); chk_regs("R4 long"); chk("R4 sel", st_oe, 1'b1);
    frame(16'h0925, 12); chk_regs("R4 12bit"); chk("R4 sel", st_oe, 1'b1);
    frame(16'h0093, 5);  chk_regs("R4 5bit");  chk("R4 sel", st_oe, 1'b1);

    // R7: re-select without latch
    fok = 1;
    shift(16'h00D3, 8);
    wclk(2);
    chk("R7 reselect", {st_oe, st}, 2'b11);
    fok = 0; wclk(2);
    chk("R7 reselect", {st_oe, st}, 2'b10);
    shift(16'h0000, 8); latch();   // 16 bits, upper byte 0x00: ignored
    chk_regs("R7 R4");

    // R8 R9 R10: counter values via completion flag
    begin
      int vals[7];
      vals = '{1, 2, 15, 16, 17, 90, 255};
      for (int k = 0; k < 7; k++) begin
        frame({8'h00, 4'hC, 4'(vals[k] >> 4)}, 8);
        frame({8'h00, 4'hB, 4'(vals[k])}, 8);
        chk("R8 loaded", {st_oe, st}, 2'b11);
        for (int p = 1; p < vals[k]; p++) trk_pulse();
        chk("R10 before zero", st, 1'b1);
        trk_pulse();
        chk("R9 reached zero", st, 1'b0);
        trk_pulse();
        chk("R9 hold zero", st, 1'b0);
      end
    end
    // zero load keeps done low
    frame(16'h00C0, 8); frame(16'h00B0, 8);
    chk("R10 zero load", {st_oe, st}, 2'b10);

    // R10 toggle flag: load 3, select toggle by the high write
    frame(16'h00B3, 8);
    frame(16'h00C0, 8);
    t0 = st;
    chk("R5 tog oe", st_oe, 1'b1);
    for (int p = 0; p < 3; p++) begin
      trk_pulse();
      t0 = ~t0;
      chk("R10 toggle", st, t0);
    end
    trk_pulse();
    chk("R10 no toggle at zero", st, t0);
    // R8: high nibble write keeps stored low nibble (3) -> 0x13
    frame(16'h00C1, 8);
    frame(16'h0000, 0);
    for (int p = 0; p < 19; p++) trk_pulse();
    chk("R10 toggle parity", st, t0 ^ 1'b1);
    frame(16'h00B5, 8);   // now 0x15: reload
    chk("R8 reload done", st, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule